// File: doc/BRIEF.md
# Free Rename-Tag Pool

This block keeps the set of rename tags that are not in use by any instruction in flight. When reset is released the pool already holds every tag value, because at that point no instruction owns a tag. The dispatch stage raises an allocate request. In that same cycle it receives a tag and a grant, or no grant when the pool has run dry, and dispatch then stalls.

When a result has been broadcast on the common data bus, its tag is sent back through a return strobe. Returned tags come back in any order. Each one is queued behind the tags still waiting, and it is handed out again when its turn comes.

Internally the pool is a circular buffer with a read pointer and a write pointer. An allocation advances the read pointer and a return advances the write pointer. Each pointer carries one extra wrap bit, so a completely full pool and an empty pool can be told apart.

Top module: `free_tag_pool`

## Requirements
- R1: While reset is held and in the first cycle after it, `full`=1, `empty`=0, `count`=64 and `ret_err`=0.
- R2: After reset the pool hands out the tags in ascending order: 0, 1, 2, … 63.
- R3: An allocate request to a non-empty pool gets `alloc_grant`=1 and a valid `alloc_tag` in the same cycle. `count` is one lower after the next rising edge.
- R4: When `count`=0 and no return is present, an allocate request gets `alloc_grant`=0 and `count` stays 0.
- R5: A return to a pool that is not full raises `count` by one after the next edge. Returned tags are handed out again in the order in which they were returned, whatever order they were issued in.
- R6: An allocate and an accepted return in the same cycle, with the pool neither empty nor full, are both honoured, and `count` is unchanged.
- R7: When the pool is empty, a return in the same cycle as an allocate request is passed straight through. `alloc_grant`=1, `alloc_tag` equals `ret_tag`, and `count` stays 0.
- R8: A return while `full`=1 sets `ret_err`=1 in that cycle. The return is discarded: `count` stays 64 and the next tag handed out is unchanged.
- R9: `full` is 1 exactly when `count`=64, and `empty` is 1 exactly when `count`=0.
- R10: Both pointers wrap around. After a complete drain-and-refill cycle the pool keeps handing out tags in the order they were returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; preloads every tag |
| alloc_req | input | 1 | Dispatch asks for a free tag |
| alloc_grant | output | 1 | A tag is handed out this cycle |
| alloc_tag | output | 6 | Tag handed out (valid with `alloc_grant`) |
| empty | output | 1 | No tag held in the pool |
| ret_valid | input | 1 | A freed tag is returned this cycle |
| ret_tag | input | 6 | Tag being returned |
| full | output | 1 | Pool holds every tag |
| count | output | 7 | Number of tags held |
| ret_err | output | 1 | Return arrived while full and was dropped |

## Verification
`alloc_grant`, `alloc_tag` and `ret_err` are combinational, so they are due in the same cycle as the stimulus. The bench reads them one time unit after it drives its inputs on the falling edge, before the next rising edge. `count`, `full` and `empty` change on the rising edge that follows the stimulus, and the bench reads them one time unit after that edge. The stimulus table and the directed drain, pass-through and wrap tests all follow this same two-point sampling.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;

  // Kind of pool activity in one cycle, brought out for the checker.
  typedef enum logic [1:0] {
    POOL_IDLE = 2'd0,
    POOL_TAKE = 2'd1,
    POOL_GIVE = 2'd2,
    POOL_SWAP = 2'd3
  } pool_op_e;

  // Occupancy from wrap-extended pointers: difference modulo 2^ptr_w.
  function automatic int unsigned fill_level(int unsigned wp, int unsigned rp,
                                             int unsigned ptr_w);
    int unsigned span;
    span = 32'd1 << ptr_w;
    return (wp + span - rp) % span;
  endfunction

  // Pointer advance modulo 2^ptr_w.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned ptr_w);
    return (p + 1) % (32'd1 << ptr_w);
  endfunction

endpackage

// File: rtl/tagpool_store.sv
module tagpool_store #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int DEPTH = 1 << TAG_W;

  logic [TAG_W-1:0] slot [DEPTH];

  // One register per slot; reset preloads slot i with tag value i.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] INIT = TAG_W'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[i] <= INIT;
      else if (wr_en && (wr_idx == INIT))
        slot[i] <= wr_tag;
    end
  end

  assign rd_tag = slot[rd_idx];
endmodule

// File: rtl/tagpool_ctrl.sv
module tagpool_ctrl
  import tagpool_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             ret_valid,
  output logic             take_store,
  output logic             write_store,
  output logic             bypass_hit,
  output logic             give_drop,
  output pool_op_e         op,
  output logic [TAG_W-1:0] rd_idx,
  output logic [TAG_W-1:0] wr_idx,
  output logic [TAG_W:0]   level,
  output logic             is_full,
  output logic             is_empty
);
  localparam int PTR_W = TAG_W + 1;
  localparam int DEPTH = 1 << TAG_W;
  localparam logic [PTR_W-1:0] WR_INIT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  assign level    = PTR_W'(fill_level(32'(wr_ptr), 32'(rd_ptr), PTR_W));
  assign is_full  = (level == PTR_W'(DEPTH));
  assign is_empty = (level == '0);

  always_comb begin
    bypass_hit  = alloc_req && ret_valid && is_empty;
    take_store  = alloc_req && !is_empty;
    give_drop   = ret_valid && is_full;
    write_store = ret_valid && !is_full && !bypass_hit;
    unique case ({write_store, take_store})
      2'b01:   op = POOL_TAKE;
      2'b10:   op = POOL_GIVE;
      2'b11:   op = POOL_SWAP;
      default: op = POOL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= WR_INIT;
    end else begin
      if (take_store)  rd_ptr <= PTR_W'(ptr_step(32'(rd_ptr), PTR_W));
      if (write_store) wr_ptr <= PTR_W'(ptr_step(32'(wr_ptr), PTR_W));
    end
  end

  assign rd_idx = rd_ptr[TAG_W-1:0];
  assign wr_idx = wr_ptr[TAG_W-1:0];
endmodule

// File: rtl/free_tag_pool.sv
module free_tag_pool
  import tagpool_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_grant,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             empty,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  output logic             full,
  output logic [TAG_W:0]   count,
  output logic             ret_err
);
  logic             take_store, write_store, bypass_hit, give_drop;
  pool_op_e         op;
  logic [TAG_W-1:0] rd_idx, wr_idx, head_tag;

  tagpool_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .ret_valid(ret_valid),
    .take_store(take_store), .write_store(write_store),
    .bypass_hit(bypass_hit), .give_drop(give_drop), .op(op),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .level(count),
    .is_full(full), .is_empty(empty)
  );

  tagpool_store #(.TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(write_store), .wr_idx(wr_idx),
    .wr_tag(ret_tag), .rd_idx(rd_idx), .rd_tag(head_tag)
  );

  assign alloc_grant = take_store || bypass_hit;
  assign alloc_tag   = bypass_hit ? ret_tag : head_tag;
  assign ret_err     = give_drop;
endmodule

// File: rtl/free_tag_pool_chk.sv
module free_tag_pool_chk
  import tagpool_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_grant,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             empty,
  input logic             ret_valid,
  input logic [TAG_W-1:0] ret_tag,
  input logic             full,
  input logic [TAG_W:0]   count,
  input logic             ret_err,
  input pool_op_e         op
);
  localparam int DEPTH = 1 << TAG_W;

  // R3: a lone grant lowers the level by one
  a_r3_take_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant && !ret_valid) |=> (count == $past(count) - 1'b1));

  // R4: nothing is granted from an empty pool unless a return passes through
  a_r4_no_grant_dry: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant && empty) |-> ret_valid);

  // R5: a lone accepted return raises the level by one
  a_r5_give_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !full && !alloc_req) |=> (count == $past(count) + 1'b1));

  // R6: a swap keeps the level
  a_r6_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == POOL_SWAP) |=> $stable(count));

  // R7: pass-through on an empty pool
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && ret_valid && alloc_req) |-> (alloc_grant && alloc_tag == ret_tag));

  // R8: a dropped return leaves the pool full when nothing is taken
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_err && !alloc_req) |=> (full && $stable(count)));

  // R9: flags never both set and the level never exceeds the pool size
  a_r9_flags_sane: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty) && (count <= (TAG_W+1)'(DEPTH)));
endmodule

bind free_tag_pool free_tag_pool_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
  .alloc_tag(alloc_tag), .empty(empty), .ret_valid(ret_valid),
  .ret_tag(ret_tag), .full(full), .count(count), .ret_err(ret_err), .op(op)
);

// File: tb/sim_free_tag_pool.sv
module sim_free_tag_pool;
  localparam int PERIOD = 10;
  localparam int TW     = 6;
  localparam int NTAG   = 1 << TW;

  logic          clk = 0, rst_n = 0;
  logic          alloc_req = 0, ret_valid = 0;
  logic [TW-1:0] ret_tag = '0;
  logic          alloc_grant, empty, full, ret_err;
  logic [TW-1:0] alloc_tag;
  logic [TW:0]   count;
  int            n_chk = 0, n_fail = 0;

  free_tag_pool #(.TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
    .alloc_tag(alloc_tag), .empty(empty), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .full(full), .count(count), .ret_err(ret_err)
  );

  always #(PERIOD/2) clk = ~clk;

  // Vector: {areq, rv, rtag[5:0], exp_grant, exp_tag[5:0], exp_count[6:0], exp_err}
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd0, 1'b1, 6'd0, 7'd63, 1'b0},
    {1'b1, 1'b0, 6'd0, 1'b1, 6'd1, 7'd62, 1'b0},
    {1'b0, 1'b1, 6'd0, 1'b0, 6'd0, 7'd63, 1'b0},
    {1'b1, 1'b1, 6'd1, 1'b1, 6'd2, 7'd63, 1'b0},
    {1'b0, 1'b1, 6'd2, 1'b0, 6'd0, 7'd64, 1'b0},
    {1'b0, 1'b1, 6'd9, 1'b0, 6'd0, 7'd64, 1'b1},
    {1'b1, 1'b0, 6'd0, 1'b1, 6'd3, 7'd63, 1'b0},
    {1'b1, 1'b1, 6'd3, 1'b1, 6'd4, 7'd63, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Drive on the falling edge; combinational outputs settle 1 unit later.
  task automatic drive(input logic a, input logic r, input logic [TW-1:0] t);
    @(negedge clk);
    alloc_req = a; ret_valid = r; ret_tag = t;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; alloc_req = 0; ret_valid = 0;
    repeat (2) @(posedge clk);
    #1;
    check(full && !empty && count == 7'd64 && !ret_err, "R1 during reset", int'(count), NTAG);
    @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  initial begin
    #(PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit mism;
    do_reset();
    check(full && !empty && count == 7'd64, "R1 after release", int'(count), NTAG);
    check(full && !empty, "R9 full flag at 64", int'(full), 1);

    // Table walk: R2 R3 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      drive(v[22], v[21], v[20:15]);
      check(alloc_grant == v[14], $sformatf("R3 grant step %0d", i), int'(alloc_grant), int'(v[14]));
      if (v[14])
        check(alloc_tag == v[13:8], $sformatf("R2/R5 tag step %0d", i), int'(alloc_tag), int'(v[13:8]));
      check(ret_err == v[0], $sformatf("R8 err step %0d", i), int'(ret_err), int'(v[0]));
      after_edge();
      check(count == v[7:1], $sformatf("R6 count step %0d", i), int'(count), int'(v[7:1]));
    end
    drive(0, 0, '0);

    // Drain from reset: ascending order, then empty (R2, R4, R9)
    do_reset();
    mism = 0;
    for (int i = 0; i < NTAG; i++) begin
      drive(1, 0, '0);
      if (!alloc_grant || alloc_tag != TW'(i)) mism = 1;
      after_edge();
    end
    check(!mism, "R2 ascending drain", int'(mism), 0);
    check(empty && !full && count == 0, "R9 empty flag at 0", int'(count), 0);
    drive(1, 0, '0);
    check(!alloc_grant, "R4 no grant when empty", int'(alloc_grant), 0);
    after_edge();
    check(count == 0, "R4 count stays 0", int'(count), 0);

    // Pass-through while empty (R7)
    drive(1, 1, TW'(40));
    check(alloc_grant && alloc_tag == TW'(40), "R7 bypass tag", int'(alloc_tag), 40);
    after_edge();
    check(count == 0 && empty, "R7 count stays 0", int'(count), 0);

    // Out-of-order returns reissued in return order; pointers wrap (R5, R10)
    for (int i = 0; i < 10; i++) begin
      drive(0, 1, TW'(NTAG - 1 - i));
      after_edge();
    end
    check(count == 10, "R5 ten returns", int'(count), 10);
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      drive(1, 0, '0);
      if (!alloc_grant || alloc_tag != TW'(NTAG - 1 - i)) mism = 1;
      after_edge();
    end
    check(!mism, "R5 return order kept", int'(mism), 0);
    for (int i = 0; i < NTAG; i++) begin
      drive(0, 1, TW'((i * 5) % NTAG));
      after_edge();
    end
    check(full && count == 7'd64, "R10 refill to full", int'(count), NTAG);
    drive(0, 1, TW'(7));
    check(ret_err, "R8 err when full", int'(ret_err), 1);
    after_edge();
    check(count == 7'd64, "R8 return dropped", int'(count), NTAG);
    mism = 0;
    for (int i = 0; i < NTAG; i++) begin
      drive(1, 0, '0);
      if (!alloc_grant || alloc_tag != TW'((i * 5) % NTAG)) mism = 1;
      after_edge();
    end
    check(!mism, "R10 order after wrap", int'(mism), 0);
    check(empty && count == 0, "R10 empty after wrap drain", int'(count), 0);
    drive(0, 0, '0);
    finish_run();
  end
endmodule